// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address, given as a segment number and an offset, into a physical memory address. A register-held segment table supplies, for each segment, an access byte, a length and a base address. The table is split in two halves of equal size. Requests made in user mode look up the lower half, and requests made in privileged mode look up the upper half.

Software or a boot sequencer fills the table through a write port. After that, a requester pulses a valid strobe with a mode bit, a segment number and an offset. One clock later the block reports exactly one of three outcomes. A successful translation raises a done strobe with the physical address. A missing or out-of-range segment raises a segment fault. An offset beyond the segment's length raises an address fault. The segment check wins when both would apply.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset all output strobes are low, paddr_o is zero and every table entry has access byte zero, so any translation returns a segment fault.
- R2: The table index is the segment number plus NUM_SEG when req_priv_i is 1, or the segment number alone when it is 0; entries 0..NUM_SEG-1 serve user mode and NUM_SEG..2*NUM_SEG-1 serve privileged mode.
- R3: A request that hits an entry whose access byte is zero raises seg_fault_o, and paddr_o stays zero on any cycle where done_o is low.
- R4: A segment number equal to or larger than NUM_SEG raises seg_fault_o whatever the table holds.
- R5: An offset greater than or equal to the entry's length raises addr_fault_o, unless the request already raises a segment fault, which takes priority.
- R6: On success done_o rises and paddr_o equals the entry base plus the zero-extended offset, modulo 2^16.
- R7: The outcome appears in the cycle after the request is sampled, with exactly one of done_o, seg_fault_o, addr_fault_o high for that one cycle; with no request, all three stay low.
- R8: A table write presented in the same cycle as a request is discarded, and the request uses the table as it stood before.
- R9: A table write with no request in the same cycle updates the indexed entry (8-bit access byte, 8-bit length, 16-bit base), and a request in any later cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 3 | Table entry index (upper half is privileged) |
| wr_acc_i | input | 8 | Access byte; zero marks the segment absent |
| wr_len_i | input | 8 | Segment length in words |
| wr_base_i | input | 16 | Segment base physical address |
| req_valid_i | input | 1 | Translation request strobe |
| req_priv_i | input | 1 | 1 selects privileged (upper) half |
| req_seg_i | input | 4 | Logical segment number |
| req_off_i | input | 8 | Logical offset |
| done_o | output | 1 | Translation succeeded |
| paddr_o | output | 16 | Physical address, zero unless done_o |
| seg_fault_o | output | 1 | Segment missing or out of range |
| addr_fault_o | output | 1 | Offset beyond segment length |

## Verification
The table write and a translation request can land in the same cycle. The bench drives both together, with the write aimed at the very entry the request reads. It then checks that the request's result matches the old entry. A follow-up request confirms that the write left no trace. Random traffic mixes writes, lookups into both halves and segment numbers past the half size, and checks each result against a bench model of the table.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int ACC_W  = 8;
  localparam int LEN_W  = 8;
  localparam int BASE_W = 16;
  localparam int OFF_W  = 8;

  typedef struct packed {
    logic [ACC_W-1:0]  acc;
    logic [LEN_W-1:0]  len;
    logic [BASE_W-1:0] base;
  } seg_entry_t;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_SEGF = 2'd1,
    RES_ADRF = 2'd2
  } xlat_res_e;
endpackage

// File: rtl/xlat_seg_table.sv
module xlat_seg_table
  import xlat_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_block_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  seg_entry_t       wr_entry_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output seg_entry_t       rd_entry_o
);
  seg_entry_t [NUM_ENT-1:0] tbl_q;
  logic                     wr_go;

  assign wr_go = wr_en_i && !wr_block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
    end else if (wr_go) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (int'(wr_idx_i) == i) tbl_q[i] <= wr_entry_i;
      end
    end
  end

  always_comb begin
    rd_entry_o = '0;
    if (int'(rd_idx_i) < NUM_ENT) rd_entry_o = tbl_q[rd_idx_i];
  end

  // R8: a colliding write leaves the table unchanged
  a_r8_blocked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_block_i) |=> $stable(tbl_q));
  // R9: an accepted write lands in the indexed entry
  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |=> (tbl_q[$past(wr_idx_i)] == $past(wr_entry_i)));
endmodule

// File: rtl/xlat_check.sv
module xlat_check
  import xlat_pkg::*;
(
  input  seg_entry_t        entry_i,
  input  logic              in_range_i,
  input  logic [OFF_W-1:0]  off_i,
  output xlat_res_e         res_o,
  output logic [BASE_W-1:0] paddr_o
);
  always_comb begin
    if (!in_range_i || entry_i.acc == '0) res_o = RES_SEGF;
    else if (LEN_W'(off_i) >= entry_i.len) res_o = RES_ADRF;
    else res_o = RES_OK;
    paddr_o = entry_i.base + BASE_W'(off_i);
  end
endmodule

// File: rtl/xlat_resp.sv
module xlat_resp
  import xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  xlat_res_e         res_i,
  input  logic [BASE_W-1:0] paddr_i,
  output logic              done_o,
  output logic              seg_fault_o,
  output logic              addr_fault_o,
  output logic [BASE_W-1:0] paddr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      seg_fault_o  <= 1'b0;
      addr_fault_o <= 1'b0;
      paddr_o      <= '0;
    end else begin
      done_o       <= req_valid_i && (res_i == RES_OK);
      seg_fault_o  <= req_valid_i && (res_i == RES_SEGF);
      addr_fault_o <= req_valid_i && (res_i == RES_ADRF);
      paddr_o      <= (req_valid_i && res_i == RES_OK) ? paddr_i : '0;
    end
  end

  a_r7_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> $onehot({done_o, seg_fault_o, addr_fault_o}));
  a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(done_o || seg_fault_o || addr_fault_o));
  a_r3_paddr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (paddr_o == '0));
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import xlat_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 4,
  localparam int NUM_ENT = 2 * NUM_SEG,
  localparam int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ACC_W-1:0]  wr_acc_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic              req_valid_i,
  input  logic              req_priv_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  output logic              done_o,
  output logic [BASE_W-1:0] paddr_o,
  output logic              seg_fault_o,
  output logic              addr_fault_o
);
  seg_entry_t        wr_entry, rd_entry;
  logic [IDX_W-1:0]  rd_idx;
  logic              in_range;
  xlat_res_e         res;
  logic [BASE_W-1:0] paddr_c;

  assign wr_entry = '{acc: wr_acc_i, len: wr_len_i, base: wr_base_i};
  assign in_range = int'(req_seg_i) < NUM_SEG;
  // upper half for privileged mode
  assign rd_idx   = IDX_W'(int'(req_seg_i) + (req_priv_i ? NUM_SEG : 0));

  xlat_seg_table #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_block_i (req_valid_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .rd_idx_i   (rd_idx),
    .rd_entry_o (rd_entry)
  );

  xlat_check u_check (
    .entry_i    (rd_entry),
    .in_range_i (in_range),
    .off_i      (req_off_i),
    .res_o      (res),
    .paddr_o    (paddr_c)
  );

  xlat_resp u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .res_i        (res),
    .paddr_i      (paddr_c),
    .done_o       (done_o),
    .seg_fault_o  (seg_fault_o),
    .addr_fault_o (addr_fault_o),
    .paddr_o      (paddr_o)
  );

  a_r4_seg_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && int'(req_seg_i) >= NUM_SEG) |=> seg_fault_o);
  a_r5_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_fault_o |-> !seg_fault_o && $past(in_range));
endmodule

// File: tb/tb_seg_xlat_unit.sv
module tb_seg_xlat_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [7:0]  wr_acc = '0;
  logic [7:0]  wr_len = '0;
  logic [15:0] wr_base = '0;
  logic        req_valid = 1'b0;
  logic        req_priv = 1'b0;
  logic [3:0]  req_seg = '0;
  logic [7:0]  req_off = '0;
  logic        done, segf, adrf;
  logic [15:0] paddr;

  int n_tests = 0;
  int n_fail = 0;

  logic [7:0]  m_acc [8];
  logic [7:0]  m_len [8];
  logic [15:0] m_base[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlat_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_acc_i(wr_acc),
    .wr_len_i(wr_len), .wr_base_i(wr_base),
    .req_valid_i(req_valid), .req_priv_i(req_priv),
    .req_seg_i(req_seg), .req_off_i(req_off),
    .done_o(done), .paddr_o(paddr),
    .seg_fault_o(segf), .addr_fault_o(adrf)
  );

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got {d,s,a,paddr}=%h expected %h", req, act, exp);
    end
  endtask

  // expected {done, segf, adrf, paddr}
  function automatic logic [18:0] model(input logic priv, input logic [3:0] seg,
                                        input logic [7:0] off);
    int idx;
    if (int'(seg) >= NSEG) return {3'b010, 16'h0};
    idx = int'(seg) + (priv ? NSEG : 0);
    if (m_acc[idx] == 8'h0) return {3'b010, 16'h0};
    if (off >= m_len[idx]) return {3'b001, 16'h0};
    return {3'b100, m_base[idx] + {8'h0, off}};
  endfunction

  task automatic do_write(input logic [2:0] i, input logic [7:0] a,
                          input logic [7:0] l, input logic [15:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_acc = a; wr_len = l; wr_base = b;
    @(negedge clk);
    wr_en = 1'b0;
    m_acc[i] = a; m_len[i] = l; m_base[i] = b;
  endtask

  task automatic do_xlat(input string req, input logic priv,
                         input logic [3:0] seg, input logic [7:0] off);
    logic [18:0] exp;
    exp = model(priv, seg, off);
    @(negedge clk);
    req_valid = 1'b1; req_priv = priv; req_seg = seg; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {done, segf, adrf, paddr}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin m_acc[i] = 0; m_len[i] = 0; m_base[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {done, segf, adrf, paddr}, 19'h0);
    rst_n = 1'b1;
    for (int s = 0; s < NSEG; s++) begin
      do_xlat("R1 cleared user entry", 1'b0, 4'(s), 8'd0);
      do_xlat("R1 cleared priv entry", 1'b1, 4'(s), 8'd0);
    end

    // R9 / R2: distinct user and privileged entries for segment 1
    do_write(3'd1, 8'h01, 8'd10, 16'h1000);
    do_write(3'd5, 8'h03, 8'd20, 16'h8000);
    do_xlat("R2 user half", 1'b0, 4'd1, 8'd15);
    do_xlat("R2 priv half", 1'b1, 4'd1, 8'd15);
    do_xlat("R6 success", 1'b0, 4'd1, 8'd9);
    do_xlat("R5 offset equals length", 1'b0, 4'd1, 8'd10);
    do_xlat("R6 offset zero", 1'b1, 4'd1, 8'd0);
    // R6 wrap of base+offset
    do_write(3'd2, 8'h80, 8'd255, 16'hFFF0);
    do_xlat("R6 wrap", 1'b0, 4'd2, 8'd32);
    // R4 out-of-range segment despite populated table
    do_xlat("R4 seg at half size", 1'b0, 4'd4, 8'd0);
    do_xlat("R4 seg high priv", 1'b1, 4'd15, 8'd0);
    // R3 / R5 priority: absent segment with zero length and large offset
    do_write(3'd3, 8'h00, 8'd0, 16'h2222);
    do_xlat("R3 zero access beats length", 1'b0, 4'd3, 8'd200);

    // R7: outcome holds one cycle only
    do_xlat("R7 pulse source", 1'b0, 4'd1, 8'd1);
    @(negedge clk);
    check("R7 strobe drops", {done, segf, adrf, paddr}, 19'h0);

    // R8: write collides with request to same entry
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd1; wr_acc = 8'h00; wr_len = 8'd1; wr_base = 16'h5555;
    req_valid = 1'b1; req_priv = 1'b0; req_seg = 4'd1; req_off = 8'd4;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R8 collide uses old entry", {done, segf, adrf, paddr}, {3'b100, 16'h1004});
    do_xlat("R8 write discarded", 1'b0, 4'd1, 8'd5);

    // random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 2) == 0) begin
        do_write(3'($urandom_range(0, 7)),
                 ($urandom_range(0, 3) == 0) ? 8'h0 : 8'($urandom_range(1, 255)),
                 8'($urandom_range(0, 255)), 16'($urandom));
      end else begin
        do_xlat("R6 random", 1'($urandom_range(0, 1)), 4'($urandom_range(0, 7)),
                8'($urandom_range(0, 255)));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule